// File: doc/BRIEF.md
# MII Carrier, Collision and Isolation Controller

This block is the control layer on the PHY side of a 10/100 media independent interface. It drives the transmit and receive nibble clocks toward the MAC or repeater, and it forwards the transmit nibble from the MAC to the line encoder. It also registers the receive nibble and its qualifiers from the line decoder toward the MAC. From transmit and receive activity it derives carrier sense and collision, following a half/full duplex selection.

Hot insertion is supported through two output-enable controls, one for the MII outputs and one for the line transmit drivers. Both stay inactive while power-on reset is asserted. They switch on together only after the reset-done indication has been high on two consecutive receive-clock edges, so a runt reset-done pulse cannot enable the drivers. The duplex selection is latched only while both directions are idle, which stops carrier sense and collision from changing behaviour in the middle of a frame.

The enable sequencer is a three-state machine clocked on the receive clock:
- **EN_ISOLATE**: reset state, with both enables off. Moves to EN_ARMED when reset-done is seen high.
- **EN_ARMED**: reset-done has been seen high once. Moves to EN_LIVE if reset-done is still high on the next edge, and otherwise returns to EN_ISOLATE.
- **EN_LIVE**: both enables on. The state holds until power-on reset is asserted again.

Top module: `mii_phy_ctl`

## Requirements
- R1: `mii_tx_clk_o` and `mii_rx_clk_o` are driven from the PHY's own line-side clocks `line_tx_clk_i` and `line_rx_clk_i`, and follow them level for level.
- R2: The transmit nibble `mac_txd_i`, `mac_txen_i` and `mac_txer_i` appear on `enc_txd_o`, `enc_txen_o` and `enc_txer_o` one transmit-clock edge after they are sampled.
- R3: The receive nibble `dec_rxd_i`, `dec_rxdv_i` and `dec_rxer_i` appear on `mii_rxd_o`, `mii_rxdv_o` and `mii_rxer_o` one receive-clock edge after they are sampled.
- R4: In half duplex (latched `full_duplex_i` = 0), `mii_crs_o` is 1 when transmit activity (`mac_txen_i`) or receive activity (`dec_rx_act_i`) is present. Transmit activity reaches `mii_crs_o` four edges after it is sampled: a capture stage, two synchronizer stages and the output register. Receive activity reaches it one edge after it is sampled.
- R5: In half duplex, `mii_col_o` is 1 exactly when transmit and receive activity overlap, with the same latencies as R4.
- R6: In full duplex (latched `full_duplex_i` = 1), `mii_crs_o` follows receive activity only, and transmit activity alone leaves it at 0.
- R7: In full duplex, `mii_col_o` is always 0.
- R8: While `por_n_i` is low, and after it rises until reset-done qualifies, `mii_oe_o` and `line_tx_oe_o` are both 0.
- R9: `mii_oe_o` and `line_tx_oe_o` rise together, on the second consecutive receive-clock edge at which `reset_done_i` is 1. A single-cycle pulse of `reset_done_i` leaves them at 0.
- R10: `full_duplex_i` is latched only on edges where the synchronized transmit activity and `dec_rx_act_i` are both 0. A change during activity has no effect until both sides are idle.
- R11: `mac_txer_i` asserted while `mac_txen_i` is 0 has no effect on `mii_crs_o` or `mii_col_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n_i | input | 1 | Power-on reset, active low, asynchronous |
| reset_done_i | input | 1 | Reset sequence finished indication |
| line_tx_clk_i | input | 1 | PHY transmit reference clock |
| line_rx_clk_i | input | 1 | PHY recovered receive clock |
| full_duplex_i | input | 1 | Duplex select, 1 = full, 0 = half |
| mac_txd_i | input | 4 | Transmit nibble from the MAC |
| mac_txen_i | input | 1 | Transmit enable from the MAC |
| mac_txer_i | input | 1 | Transmit error from the MAC |
| dec_rx_act_i | input | 1 | Receive activity from the line side |
| dec_rxd_i | input | 4 | Received nibble from the line decoder |
| dec_rxdv_i | input | 1 | Received nibble valid |
| dec_rxer_i | input | 1 | Received nibble error |
| mii_tx_clk_o | output | 1 | Transmit clock driven to the MAC |
| mii_rx_clk_o | output | 1 | Receive clock driven to the MAC |
| mii_rxd_o | output | 4 | Registered receive nibble |
| mii_rxdv_o | output | 1 | Registered receive data valid |
| mii_rxer_o | output | 1 | Registered receive error |
| mii_crs_o | output | 1 | Carrier sense |
| mii_col_o | output | 1 | Collision |
| mii_oe_o | output | 1 | Output enable for all MII outputs |
| line_tx_oe_o | output | 1 | Output enable for the line transmit pair |
| enc_txd_o | output | 4 | Forwarded transmit nibble |
| enc_txen_o | output | 1 | Forwarded transmit enable |
| enc_txer_o | output | 1 | Forwarded transmit error |

## Verification
The bench sends a one-cycle reset-done pulse. A sequencer that arms on a single sighting would switch the drivers on at that point. The bench flips the duplex input while transmit and receive overlap: a design that reads the input directly would drop collision in the middle of the frame. It also checks that the latched full-duplex mode hides transmit-only traffic from carrier sense, and it asserts transmit error without transmit enable, which a design that ORs the error into activity would report as carrier.

// File: rtl/mii_phy_ctl_pkg.sv
package mii_phy_ctl_pkg;
    typedef enum logic [1:0] {
        EN_ISOLATE = 2'd0,
        EN_ARMED   = 2'd1,
        EN_LIVE    = 2'd2
    } en_state_t;
endpackage

// File: rtl/mii_enable_seq.sv
module mii_enable_seq
    import mii_phy_ctl_pkg::*;
(
    input  logic clk_i,
    input  logic por_n_i,
    input  logic done_i,
    output logic oe_o
);
    en_state_t state_q, state_d;

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) state_q <= EN_ISOLATE;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EN_ISOLATE: if (done_i) state_d = EN_ARMED;
            EN_ARMED:   state_d = done_i ? EN_LIVE : EN_ISOLATE;
            EN_LIVE:    state_d = EN_LIVE;
            default:    state_d = EN_ISOLATE;
        endcase
    end

    always_comb begin
        oe_o = (state_q == EN_LIVE);
    end
endmodule

// File: rtl/mii_tx_capture.sv
module mii_tx_capture #(
    parameter int NIB_W = 4
) (
    input  logic             clk_i,
    input  logic             por_n_i,
    input  logic [NIB_W-1:0] txd_i,
    input  logic             txen_i,
    input  logic             txer_i,
    output logic [NIB_W-1:0] txd_o,
    output logic             txen_o,
    output logic             txer_o
);
    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            txd_o  <= '0;
            txen_o <= 1'b0;
            txer_o <= 1'b0;
        end else begin
            txd_o  <= txd_i;
            txen_o <= txen_i;
            txer_o <= txer_i;
        end
    end
endmodule

// File: rtl/mii_rx_carrier.sv
module mii_rx_carrier #(
    parameter int NIB_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             por_n_i,
    input  logic             tx_act_i,
    input  logic             rx_act_i,
    input  logic             full_duplex_i,
    input  logic [NIB_W-1:0] rxd_i,
    input  logic             rxdv_i,
    input  logic             rxer_i,
    output logic [NIB_W-1:0] rxd_o,
    output logic             rxdv_o,
    output logic             rxer_o,
    output logic             crs_o,
    output logic             col_o,
    output logic             tx_seen_o,
    output logic             dup_full_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   dup_q;
    logic                   idle;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk_i or negedge por_n_i) begin
                if (!por_n_i) sync_q[g] <= 1'b0;
                else if (g == 0) sync_q[g] <= tx_act_i;
                else             sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign tx_seen_o  = sync_q[LAST];
    assign dup_full_o = dup_q;
    assign idle       = !sync_q[LAST] && !rx_act_i;

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            dup_q  <= 1'b0;
            crs_o  <= 1'b0;
            col_o  <= 1'b0;
            rxd_o  <= '0;
            rxdv_o <= 1'b0;
            rxer_o <= 1'b0;
        end else begin
            if (idle) dup_q <= full_duplex_i;
            crs_o  <= rx_act_i || (!dup_q && sync_q[LAST]);
            col_o  <= !dup_q && rx_act_i && sync_q[LAST];
            rxd_o  <= rxd_i;
            rxdv_o <= rxdv_i;
            rxer_o <= rxer_i;
        end
    end
endmodule

// File: rtl/mii_phy_ctl.sv
module mii_phy_ctl #(
    parameter int NIB_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             por_n_i,
    input  logic             reset_done_i,
    input  logic             line_tx_clk_i,
    input  logic             line_rx_clk_i,
    input  logic             full_duplex_i,
    input  logic [NIB_W-1:0] mac_txd_i,
    input  logic             mac_txen_i,
    input  logic             mac_txer_i,
    input  logic             dec_rx_act_i,
    input  logic [NIB_W-1:0] dec_rxd_i,
    input  logic             dec_rxdv_i,
    input  logic             dec_rxer_i,
    output logic             mii_tx_clk_o,
    output logic             mii_rx_clk_o,
    output logic [NIB_W-1:0] mii_rxd_o,
    output logic             mii_rxdv_o,
    output logic             mii_rxer_o,
    output logic             mii_crs_o,
    output logic             mii_col_o,
    output logic             mii_oe_o,
    output logic             line_tx_oe_o,
    output logic [NIB_W-1:0] enc_txd_o,
    output logic             enc_txen_o,
    output logic             enc_txer_o
);
    logic oe;
    logic tx_seen;
    logic dup_full;

    assign mii_tx_clk_o = line_tx_clk_i;
    assign mii_rx_clk_o = line_rx_clk_i;
    assign mii_oe_o     = oe;
    assign line_tx_oe_o = oe;

    mii_enable_seq u_seq (
        .clk_i   (line_rx_clk_i),
        .por_n_i (por_n_i),
        .done_i  (reset_done_i),
        .oe_o    (oe)
    );

    mii_tx_capture #(.NIB_W(NIB_W)) u_tx (
        .clk_i   (line_tx_clk_i),
        .por_n_i (por_n_i),
        .txd_i   (mac_txd_i),
        .txen_i  (mac_txen_i),
        .txer_i  (mac_txer_i),
        .txd_o   (enc_txd_o),
        .txen_o  (enc_txen_o),
        .txer_o  (enc_txer_o)
    );

    mii_rx_carrier #(.NIB_W(NIB_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk_i         (line_rx_clk_i),
        .por_n_i       (por_n_i),
        .tx_act_i      (enc_txen_o),
        .rx_act_i      (dec_rx_act_i),
        .full_duplex_i (full_duplex_i),
        .rxd_i         (dec_rxd_i),
        .rxdv_i        (dec_rxdv_i),
        .rxer_i        (dec_rxer_i),
        .rxd_o         (mii_rxd_o),
        .rxdv_o        (mii_rxdv_o),
        .rxer_o        (mii_rxer_o),
        .crs_o         (mii_crs_o),
        .col_o         (mii_col_o),
        .tx_seen_o     (tx_seen),
        .dup_full_o    (dup_full)
    );
endmodule

// File: rtl/mii_phy_ctl_chk.sv
module mii_phy_ctl_chk (
    input logic clk_i,
    input logic por_n_i,
    input logic reset_done_i,
    input logic rx_act_i,
    input logic rxdv_i,
    input logic rxdv_o,
    input logic crs_o,
    input logic col_o,
    input logic mii_oe_o,
    input logic line_oe_o,
    input logic tx_seen,
    input logic dup_full
);
    p_rx_reg_r3: assert property (@(posedge clk_i) disable iff (!por_n_i)
        1'b1 |=> (rxdv_o == $past(rxdv_i)));

    p_col_implies_crs_r5: assert property (@(posedge clk_i) disable iff (!por_n_i)
        col_o |-> crs_o);

    p_full_no_col_r7: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (dup_full && $past(dup_full)) |-> !col_o);

    p_enables_together_r9: assert property (@(posedge clk_i) disable iff (!por_n_i)
        mii_oe_o == line_oe_o);

    p_arm_two_cycles_r9: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $rose(mii_oe_o) |-> ($past(reset_done_i) && $past(reset_done_i, 2)));

    p_duplex_hold_r10: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (tx_seen || rx_act_i) |=> $stable(dup_full));
endmodule

bind mii_phy_ctl mii_phy_ctl_chk u_chk (
    .clk_i        (line_rx_clk_i),
    .por_n_i      (por_n_i),
    .reset_done_i (reset_done_i),
    .rx_act_i     (dec_rx_act_i),
    .rxdv_i       (dec_rxdv_i),
    .rxdv_o       (mii_rxdv_o),
    .crs_o        (mii_crs_o),
    .col_o        (mii_col_o),
    .mii_oe_o     (mii_oe_o),
    .line_oe_o    (line_tx_oe_o),
    .tx_seen      (tx_seen),
    .dup_full     (dup_full)
);

// File: tb/sim_mii_phy_ctl.sv
module sim_mii_phy_ctl;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       por_n = 1'b0, done = 1'b0, fdx = 1'b0;
    logic [3:0] txd = '0, rxd = '0;
    logic       txen = 0, txer = 0, rxact = 0, rxdv = 0, rxer = 0;
    logic       tclk_o, rclk_o, rxdv_o, rxer_o, crs, col, moe, loe, etxen, etxer;
    logic [3:0] rxd_o, etxd;

    mii_phy_ctl u0 (
        .por_n_i(por_n), .reset_done_i(done), .line_tx_clk_i(clk), .line_rx_clk_i(clk),
        .full_duplex_i(fdx), .mac_txd_i(txd), .mac_txen_i(txen), .mac_txer_i(txer),
        .dec_rx_act_i(rxact), .dec_rxd_i(rxd), .dec_rxdv_i(rxdv), .dec_rxer_i(rxer),
        .mii_tx_clk_o(tclk_o), .mii_rx_clk_o(rclk_o), .mii_rxd_o(rxd_o),
        .mii_rxdv_o(rxdv_o), .mii_rxer_o(rxer_o), .mii_crs_o(crs), .mii_col_o(col),
        .mii_oe_o(moe), .line_tx_oe_o(loe), .enc_txd_o(etxd), .enc_txen_o(etxen),
        .enc_txer_o(etxer)
    );

    int checks = 0, fails = 0;

    typedef struct { logic crs; logic col; string req; } exp_t;
    exp_t exp_q[$];

    task automatic chk(input logic ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // scoreboard monitor: compares carrier/collision against queued expectations
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(crs === e.crs, {e.req, " crs"}, crs, e.crs);
            chk(col === e.col, {e.req, " col"}, col, e.col);
        end
    end

    task automatic drive_act(input logic t, input logic r, input logic ecrs,
                             input logic ecol, input string req);
        txen = t; rxact = r;
        repeat (6) @(negedge clk);
        @(posedge clk);
        exp_q.push_back('{ecrs, ecol, req});
        @(negedge clk);
        #1;
    endtask

    task automatic go_idle;
        txen = 0; rxact = 0; txer = 0;
        repeat (6) @(negedge clk);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        report();
    end

    initial begin
        // R8: isolated during power-on reset, even with reset-done high
        done = 1;
        repeat (3) @(negedge clk);
        chk(moe === 0 && loe === 0, "R8 oe in reset", moe, 0);
        done = 0;
        por_n = 1;
        repeat (3) @(negedge clk);
        chk(moe === 0 && loe === 0, "R8 oe before done", moe, 0);

        // R9: runt pulse does not enable
        done = 1;
        @(negedge clk);
        done = 0;
        repeat (3) @(negedge clk);
        chk(moe === 0, "R9 runt pulse", moe, 0);

        // R9: two consecutive edges enable both together
        done = 1;
        @(negedge clk);
        chk(moe === 0, "R9 after first edge", moe, 0);
        @(negedge clk);
        chk(moe === 1 && loe === 1, "R9 after second edge", {moe, loe}, 3);

        // R1: clocks forwarded
        chk(tclk_o === 0 && rclk_o === 0, "R1 clocks low", {tclk_o, rclk_o}, 0);
        #6;
        chk(tclk_o === 1 && rclk_o === 1, "R1 clocks high", {tclk_o, rclk_o}, 3);
        @(negedge clk);

        // R2: transmit nibble forwarded one edge later
        txd = 4'hA; txen = 1; txer = 1;
        @(posedge clk); #1;
        chk(etxd === 4'hA && etxen === 1 && etxer === 1, "R2 tx forward", etxd, 4'hA);
        @(negedge clk);
        txd = 4'h5; txen = 0; txer = 0;
        @(posedge clk); #1;
        chk(etxd === 4'h5 && etxen === 0, "R2 tx forward idle", etxd, 4'h5);
        @(negedge clk);

        // R3: receive nibble registered one edge later
        rxd = 4'h3; rxdv = 1; rxer = 1;
        @(posedge clk); #1;
        chk(rxd_o === 4'h3 && rxdv_o === 1 && rxer_o === 1, "R3 rx forward", rxd_o, 4'h3);
        @(negedge clk);
        rxd = 4'hC; rxdv = 0; rxer = 0;
        @(posedge clk); #1;
        chk(rxd_o === 4'hC && rxdv_o === 0, "R3 rx forward idle", rxd_o, 4'hC);
        @(negedge clk);

        // half duplex
        fdx = 0; go_idle();
        drive_act(0, 0, 0, 0, "R4 half idle");
        drive_act(1, 0, 1, 0, "R4 half tx only");
        drive_act(0, 1, 1, 0, "R4 half rx only");
        drive_act(1, 1, 1, 1, "R5 half overlap");

        // R10: duplex change mid-frame ignored
        fdx = 1;
        drive_act(1, 1, 1, 1, "R10 duplex held mid-frame");
        go_idle();

        // full duplex now latched
        drive_act(1, 0, 0, 0, "R6 full tx only");
        drive_act(0, 1, 1, 0, "R6 full rx only");
        drive_act(1, 1, 1, 0, "R7 full overlap");
        go_idle();

        // R11: txer without txen, half duplex
        fdx = 0; go_idle();
        txer = 1;
        drive_act(0, 0, 0, 0, "R11 txer alone");
        go_idle();

        repeat (2) @(negedge clk);
        report();
    end
endmodule